// File: doc/BRIEF.md
# USB2 PHY Analog Power-Up Sequencer

This block walks a USB2 PHY analog front end out of power-down entirely in hardware. A single start pulse launches a fixed series of control-pin changes, and each step holds for its own number of microseconds before the next one. After the last step the block releases the PLL and PHY resets. It then polls the PLL lock indication once per microsecond. If lock does not appear within the allowed number of polls, the block pulls the PLL reset low for one microsecond and tries a second time.

When the run ends, the port-control field is loaded with its non-driving-low code whether or not lock was achieved. A one-cycle done pulse reports completion. An error flag in the same cycle marks a run in which both lock attempts failed. Time is counted in clock cycles, with `CLK_PER_US` cycles making one microsecond. All control and status pins are plain levels or pulses.

Top module: `u2phy_pwrup_seq`

## Requirements
- R1: After reset every AFE control output is 0, `port_ctl` is 0, and `done` and `err` are 0.
- R2: A `start` sampled high while idle sets `afe_iso` on that clock edge, and this step lasts 10 us.
- R3: Exactly 10 us after the isolation step, `afe_iddq` is set, and this step lasts 10 us.
- R4: The next step clears `bg_pd_n`, `ldo_pd_n`, `pll_pd_n` and `core_rdy` together and loads `port_ctl` with `PCTL_ON` (default 4'h6). This step lasts 160 us.
- R5: `core_rdy` is then set for a 50 us step, after which `bg_pd_n` is set for a 200 us step.
- R6: `pwr_on_in` and `ldo_pd_n` are set on the same edge for a 10 us step, and then `pwr_ok_in` is set for a 10 us step.
- R7: The following steps are, in order: `pll_pd_n` set (10 us), `afe_iso` cleared (10 us), `afe_iddq` cleared (1 us). After these, `pll_rst_n` and `phy_rst_n` rise on the same edge. Counted from the start edge, the resets rise after 471 us.
- R8: `pll_lock` is sampled once per microsecond, first 1 us after the resets rise, and its level at any other time is ignored. The first high sample ends the run: `done` pulses, `err` stays 0, and `port_ctl` takes `PCTL_NDL` (default 4'h3) on the same edge.
- R9: When `LOCK_POLLS` samples of the first attempt all read low, `pll_rst_n` drops on the edge of the last sample and stays low for 1 us. It then rises, and polling restarts with a fresh count.
- R10: When `LOCK_POLLS` samples of the second attempt all read low, `done` and `err` pulse together on the edge of the last sample, and `port_ctl` takes `PCTL_NDL`.
- R11: A `start` pulse that arrives while a run is in progress has no effect on the sequence or its timing.
- R12: `done` is high for exactly one cycle per run, and `err` is never high without `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a run when sampled high while idle |
| pll_lock | input | 1 | PLL lock status from the PHY |
| afe_iso | output | 1 | Analog isolation enable |
| afe_iddq | output | 1 | Quiescent-current test mode enable |
| bg_pd_n | output | 1 | Bandgap power-down, active low |
| ldo_pd_n | output | 1 | LDO power-down, active low |
| pll_pd_n | output | 1 | PLL power-down, active low |
| core_rdy | output | 1 | Controller core ready |
| pwr_on_in | output | 1 | Power switch on request |
| pwr_ok_in | output | 1 | Power switch good indication |
| port_ctl | output | PCTL_W | Port-control field |
| pll_rst_n | output | 1 | PLL reset, active low |
| phy_rst_n | output | 1 | PHY reset, active low |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Lock failure after retry, valid with done |

## Verification
The full step table is checked three times, each run under a different lock pattern: lock held high from before start, lock never high, and lock rising partway through the second attempt. Each step is checked on its first cycle and on the cycle just before it, so any change in step duration or in step order is detected. The three lock patterns tell apart a lock seen on the first poll, a retry that succeeds, and a retry that fails. Holding lock high early also shows that lock is ignored before polling starts. A second run without a reset confirms that the power-down-bar and core-ready pins are actually cleared and not only left low. A start pulse sent in the middle of a run confirms that it is ignored.

// File: rtl/u2phy_pwrup_pkg.sv
package u2phy_pwrup_pkg;

  typedef struct packed {
    logic iso;
    logic iddq;
    logic bg_pd_n;
    logic ldo_pd_n;
    logic pll_pd_n;
    logic core_rdy;
    logic pwr_on;
    logic pwr_ok;
    logic pll_rst_n;
    logic phy_rst_n;
  } afe_ctl_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STEP,
    ST_POLL,
    ST_PRST
  } seq_state_e;

  localparam int unsigned LAST_TIMED = 9;
  localparam int unsigned MAX_WAIT_US = 200;

  function automatic int unsigned step_wait_us(input logic [3:0] idx);
    case (idx)
      4'd2:    return 160;
      4'd3:    return 50;
      4'd4:    return 200;
      4'd9:    return 1;
      default: return 10;
    endcase
  endfunction

  function automatic afe_ctl_t step_apply(input afe_ctl_t cur, input logic [3:0] idx);
    afe_ctl_t n;
    n = cur;
    case (idx)
      4'd0: n.iso = 1'b1;
      4'd1: n.iddq = 1'b1;
      4'd2: begin
        n.bg_pd_n  = 1'b0;
        n.ldo_pd_n = 1'b0;
        n.pll_pd_n = 1'b0;
        n.core_rdy = 1'b0;
      end
      4'd3: n.core_rdy = 1'b1;
      4'd4: n.bg_pd_n = 1'b1;
      4'd5: begin
        n.pwr_on   = 1'b1;
        n.ldo_pd_n = 1'b1;
      end
      4'd6: n.pwr_ok = 1'b1;
      4'd7: n.pll_pd_n = 1'b1;
      4'd8: n.iso = 1'b0;
      4'd9: n.iddq = 1'b0;
      default: begin
        n.pll_rst_n = 1'b1;
        n.phy_rst_n = 1'b1;
      end
    endcase
    return n;
  endfunction

endpackage

// File: rtl/pwrup_wait_timer.sv
module pwrup_wait_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= load_val;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt == '0);
endmodule

// File: rtl/pwrup_lock_poll.sv
module pwrup_lock_poll #(
  parameter int LOCK_POLLS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic miss,
  output logic exhausted
);
  localparam int PW = (LOCK_POLLS < 2) ? 1 : $clog2(LOCK_POLLS);
  localparam logic [PW-1:0] LAST = PW'(LOCK_POLLS - 1);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (miss) cnt <= cnt + 1'b1;
  end

  assign exhausted = (cnt == LAST);
endmodule

// File: rtl/pwrup_seq_fsm.sv
module pwrup_seq_fsm
  import u2phy_pwrup_pkg::*;
#(
  parameter int                CLK_PER_US = 100,
  parameter int                CNT_W      = 16,
  parameter int                PCTL_W     = 4,
  parameter logic [PCTL_W-1:0] PCTL_ON    = 'h6,
  parameter logic [PCTL_W-1:0] PCTL_NDL   = 'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pll_lock,
  input  logic              tmr_expire,
  input  logic              poll_exhausted,
  output logic              tmr_load,
  output logic [CNT_W-1:0]  tmr_val,
  output logic              poll_clr,
  output logic              poll_miss,
  output afe_ctl_t          ctl,
  output logic [PCTL_W-1:0] pctl,
  output logic              done,
  output logic              err
);
  seq_state_e  st, st_nxt;
  logic [3:0]  step, step_nxt, apply_idx;
  logic        apply, fin, fin_err, rst_lo, rst_hi, attempt;
  int unsigned wait_us;

  assign tmr_val = CNT_W'(wait_us * CLK_PER_US - 1);

  always_comb begin
    st_nxt    = st;
    step_nxt  = step;
    apply     = 1'b0;
    apply_idx = step;
    tmr_load  = 1'b0;
    wait_us   = 1;
    poll_clr  = 1'b0;
    poll_miss = 1'b0;
    fin       = 1'b0;
    fin_err   = 1'b0;
    rst_lo    = 1'b0;
    rst_hi    = 1'b0;
    case (st)
      ST_IDLE: if (start) begin
        apply     = 1'b1;
        apply_idx = 4'd0;
        tmr_load  = 1'b1;
        wait_us   = step_wait_us(4'd0);
        step_nxt  = 4'd0;
        st_nxt    = ST_STEP;
      end
      ST_STEP: if (tmr_expire) begin
        apply     = 1'b1;
        apply_idx = step + 4'd1;
        tmr_load  = 1'b1;
        step_nxt  = step + 4'd1;
        if (step == 4'(LAST_TIMED)) begin
          poll_clr = 1'b1;
          st_nxt   = ST_POLL;
        end else begin
          wait_us = step_wait_us(step + 4'd1);
        end
      end
      ST_POLL: if (tmr_expire) begin
        if (pll_lock) begin
          fin    = 1'b1;
          st_nxt = ST_IDLE;
        end else if (poll_exhausted) begin
          if (!attempt) begin
            rst_lo   = 1'b1;
            tmr_load = 1'b1;
            st_nxt   = ST_PRST;
          end else begin
            fin     = 1'b1;
            fin_err = 1'b1;
            st_nxt  = ST_IDLE;
          end
        end else begin
          poll_miss = 1'b1;
          tmr_load  = 1'b1;
        end
      end
      ST_PRST: if (tmr_expire) begin
        rst_hi   = 1'b1;
        tmr_load = 1'b1;
        poll_clr = 1'b1;
        st_nxt   = ST_POLL;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      step    <= '0;
      ctl     <= '0;
      pctl    <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      attempt <= 1'b0;
    end else begin
      st   <= st_nxt;
      step <= step_nxt;
      done <= fin;
      err  <= fin_err;
      if (apply)                       ctl <= step_apply(ctl, apply_idx);
      if (rst_lo)                      ctl.pll_rst_n <= 1'b0;
      if (rst_hi)                      ctl.pll_rst_n <= 1'b1;
      if (apply && apply_idx == 4'd2)  pctl <= PCTL_ON;
      if (fin)                         pctl <= PCTL_NDL;
      if (st == ST_IDLE && start)      attempt <= 1'b0;
      if (rst_lo)                      attempt <= 1'b1;
    end
  end
endmodule

// File: rtl/u2phy_pwrup_seq.sv
module u2phy_pwrup_seq
  import u2phy_pwrup_pkg::*;
#(
  parameter int                CLK_PER_US = 100,
  parameter int                LOCK_POLLS = 100,
  parameter int                PCTL_W     = 4,
  parameter logic [PCTL_W-1:0] PCTL_ON    = 'h6,
  parameter logic [PCTL_W-1:0] PCTL_NDL   = 'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pll_lock,
  output logic              afe_iso,
  output logic              afe_iddq,
  output logic              bg_pd_n,
  output logic              ldo_pd_n,
  output logic              pll_pd_n,
  output logic              core_rdy,
  output logic              pwr_on_in,
  output logic              pwr_ok_in,
  output logic [PCTL_W-1:0] port_ctl,
  output logic              pll_rst_n,
  output logic              phy_rst_n,
  output logic              done,
  output logic              err
);
  localparam int CNT_W = $clog2(MAX_WAIT_US * CLK_PER_US + 1);

  logic             tmr_load, tmr_expire, poll_clr, poll_miss, poll_exhausted;
  logic [CNT_W-1:0] tmr_val;
  afe_ctl_t         ctl;

  pwrup_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expire(tmr_expire)
  );

  pwrup_lock_poll #(.LOCK_POLLS(LOCK_POLLS)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .miss(poll_miss), .exhausted(poll_exhausted)
  );

  pwrup_seq_fsm #(
    .CLK_PER_US(CLK_PER_US), .CNT_W(CNT_W), .PCTL_W(PCTL_W),
    .PCTL_ON(PCTL_ON), .PCTL_NDL(PCTL_NDL)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_lock(pll_lock),
    .tmr_expire(tmr_expire), .poll_exhausted(poll_exhausted),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .poll_clr(poll_clr), .poll_miss(poll_miss),
    .ctl(ctl), .pctl(port_ctl), .done(done), .err(err)
  );

  assign afe_iso   = ctl.iso;
  assign afe_iddq  = ctl.iddq;
  assign bg_pd_n   = ctl.bg_pd_n;
  assign ldo_pd_n  = ctl.ldo_pd_n;
  assign pll_pd_n  = ctl.pll_pd_n;
  assign core_rdy  = ctl.core_rdy;
  assign pwr_on_in = ctl.pwr_on;
  assign pwr_ok_in = ctl.pwr_ok;
  assign pll_rst_n = ctl.pll_rst_n;
  assign phy_rst_n = ctl.phy_rst_n;
endmodule

// File: rtl/u2phy_pwrup_chk.sv
module u2phy_pwrup_chk #(
  parameter int                PCTL_W   = 4,
  parameter logic [PCTL_W-1:0] PCTL_ON  = 'h6,
  parameter logic [PCTL_W-1:0] PCTL_NDL = 'h3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              afe_iso,
  input logic              afe_iddq,
  input logic              ldo_pd_n,
  input logic              pll_pd_n,
  input logic              core_rdy,
  input logic              pwr_on_in,
  input logic [PCTL_W-1:0] port_ctl,
  input logic              pll_rst_n,
  input logic              phy_rst_n,
  input logic              done,
  input logic              err
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R12
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) err |-> done);
  // R10
  ndl_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> port_ctl == PCTL_NDL);
  // R4
  core_after_pctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rdy) |-> port_ctl == PCTL_ON);
  // R6
  pwron_with_ldo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on_in) |-> ldo_pd_n);
  // R7
  phy_rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_rst_n) |-> (!afe_iso && !afe_iddq && pll_pd_n && pll_rst_n));
  // R9
  pll_rst_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_rst_n) |-> (phy_rst_n && !done));
endmodule

bind u2phy_pwrup_seq u2phy_pwrup_chk #(
  .PCTL_W(PCTL_W), .PCTL_ON(PCTL_ON), .PCTL_NDL(PCTL_NDL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .afe_iso(afe_iso), .afe_iddq(afe_iddq),
  .ldo_pd_n(ldo_pd_n), .pll_pd_n(pll_pd_n), .core_rdy(core_rdy),
  .pwr_on_in(pwr_on_in), .port_ctl(port_ctl), .pll_rst_n(pll_rst_n),
  .phy_rst_n(phy_rst_n), .done(done), .err(err)
);

// File: tb/u2phy_pwrup_seq_bench.sv
module u2phy_pwrup_seq_bench;
  localparam int CLK_NS = 10;
  localparam int CPU    = 4;
  localparam int POLLS  = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pll_lock = 1'b0;
  logic afe_iso, afe_iddq, bg_pd_n, ldo_pd_n, pll_pd_n, core_rdy;
  logic pwr_on_in, pwr_ok_in, pll_rst_n, phy_rst_n, done, err;
  logic [3:0] port_ctl;

  int checks = 0, errors = 0, rel = 0;

  // step offsets in us and expected {iso,iddq,bg,ldo,pll_pd,core,on,ok,pll_rst,phy_rst,pctl}
  localparam int OFF [0:10] = '{0, 10, 20, 180, 230, 430, 440, 450, 460, 470, 471};
  localparam logic [13:0] VEC [0:10] = '{
    {10'b1000000000, 4'h0}, {10'b1100000000, 4'h0}, {10'b1100000000, 4'h6},
    {10'b1100010000, 4'h6}, {10'b1110010000, 4'h6}, {10'b1111011000, 4'h6},
    {10'b1111011100, 4'h6}, {10'b1111111100, 4'h6}, {10'b0111111100, 4'h6},
    {10'b0011111100, 4'h6}, {10'b0011111111, 4'h6}};

  always #(CLK_NS/2) clk = ~clk;

  u2phy_pwrup_seq #(.CLK_PER_US(CPU), .LOCK_POLLS(POLLS)) u_u2phy_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_lock(pll_lock),
    .afe_iso(afe_iso), .afe_iddq(afe_iddq), .bg_pd_n(bg_pd_n), .ldo_pd_n(ldo_pd_n),
    .pll_pd_n(pll_pd_n), .core_rdy(core_rdy), .pwr_on_in(pwr_on_in), .pwr_ok_in(pwr_ok_in),
    .port_ctl(port_ctl), .pll_rst_n(pll_rst_n), .phy_rst_n(phy_rst_n), .done(done), .err(err)
  );

  function automatic logic [13:0] obs();
    return {afe_iso, afe_iddq, bg_pd_n, ldo_pd_n, pll_pd_n, core_rdy,
            pwr_on_in, pwr_ok_in, pll_rst_n, phy_rst_n, port_ctl};
  endfunction

  function automatic string req_of(input int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3, 4: return "R5";
      5, 6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at rel %0d: act=%h exp=%h", req, rel, act, exp);
    end
  endtask

  task automatic adv_to(input int n);
    while (rel < n) begin
      @(negedge clk);
      rel++;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic launch();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rel = 0;
  endtask

  task automatic walk_table(input bit poke_start);
    for (int k = 0; k <= 10; k++) begin
      if (k > 0) begin
        adv_to(OFF[k] * CPU - 1);
        chk({req_of(k - 1), " hold"}, 32'(obs()), 32'(VEC[k - 1]));
      end
      adv_to(OFF[k] * CPU);
      chk(req_of(k), 32'(obs()), 32'(VEC[k]));
      if (k == 2 && poke_start) begin
        adv_to(100);
        start = 1'b1;   // R11: ignored mid-run
        @(negedge clk);
        rel++;
        start = 1'b0;
        chk("R11", 32'(obs()), 32'(VEC[2]));
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog: act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1", {18'd0, obs()}, 32'd0);
    chk("R1 flags", {30'd0, done, err}, 32'd0);

    // lock high before polling: ignored, first poll succeeds (R8), mid-run start (R11)
    pll_lock = 1'b1;
    launch();
    walk_table(1'b1);
    adv_to(1887);
    chk("R8 early", {30'd0, done, err}, 32'd0);
    adv_to(1888);
    chk("R8 done", {30'd0, done, err}, 32'b10);
    chk("R8 pctl", 32'(port_ctl), 32'h3);
    adv_to(1889);
    chk("R12 pulse", {31'd0, done}, 32'd0);

    // second run without reset: step 2 clears power-down bars and core-ready (R4)
    launch();
    adv_to(79);
    chk("R4 prev", 32'(obs()), {18'd0, 10'b1111111111, 4'h3});
    adv_to(80);
    chk("R4 clear", 32'(obs()), {18'd0, 10'b1100001111, 4'h6});
    adv_to(1888);
    chk("R8 rerun", {30'd0, done, err}, 32'b10);

    // never locks: retry then error (R9, R10)
    do_reset();
    pll_lock = 1'b0;
    launch();
    walk_table(1'b0);
    adv_to(1895);
    chk("R9 before", {31'd0, pll_rst_n}, 32'd1);
    adv_to(1896);
    chk("R9 low", {31'd0, pll_rst_n}, 32'd0);
    adv_to(1899);
    chk("R9 held", {31'd0, pll_rst_n}, 32'd0);
    adv_to(1900);
    chk("R9 high", {31'd0, pll_rst_n}, 32'd1);
    adv_to(1911);
    chk("R10 early", {30'd0, done, err}, 32'd0);
    adv_to(1912);
    chk("R10 done", {30'd0, done, err}, 32'b11);
    chk("R10 pctl", 32'(port_ctl), 32'h3);
    adv_to(1913);
    chk("R12 err pulse", {30'd0, done, err}, 32'd0);

    // lock appears during the second attempt (R9 success path)
    do_reset();
    pll_lock = 1'b0;
    launch();
    walk_table(1'b0);
    adv_to(1905);
    pll_lock = 1'b1;
    adv_to(1907);
    chk("R9 wait", {30'd0, done, err}, 32'd0);
    adv_to(1908);
    chk("R9 relock", {30'd0, done, err}, 32'b10);
    chk("R9 pctl", 32'(port_ctl), 32'h3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule